// File: doc/BRIEF.md
# Pipelined Zero-Turnaround SRAM Controller

This block sits between a simple user request port and a pipelined synchronous SRAM of the zero-bus-turnaround kind. Such a memory registers the address and control on one clock edge, and it moves the data word for that access two edges later. This holds for reads (the memory drives the word) and for writes (the memory samples the word). The controller registers each user request onto the memory command pins. It carries the write word through a matched delay line so that the word reaches the shared data bus exactly when the memory samples it. It tracks each read through a delay line of the same length, so the returned word is captured and flagged valid on the right cycle.

Reads and writes share one data bus, and both directions occupy it at the same fixed offset from their command. Any mix of reads and writes can therefore be issued on consecutive cycles with no idle cycle between them. The request side has no back-pressure: no ready signal exists and the controller accepts a strobe on every cycle. The read-return side is a valid-only stream that the consumer must take in the cycle it is flagged. Each access moves one full word. The byte enables are held on and the burst control is held in load mode.

Top module: `zbt_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, `mem_ce_n` and `mem_we_n` are high, and `mem_dq_oe` and `usr_rvalid` are low.
- R2: A request (`usr_wr` or `usr_rd` high) sampled on a rising edge puts `mem_ce_n` low and `mem_addr` equal to the request address for the following cycle. A cycle with neither strobe leaves `mem_ce_n` high for the following cycle.
- R3: When `usr_wr` and `usr_rd` are both high on the same edge, the request is a write (`mem_we_n` low), and no read data is returned for it. A read alone drives `mem_we_n` high.
- R4: The write word sampled with a write request on edge n is driven on `mem_dq_out`, with `mem_dq_oe` high, for exactly the cycle that follows edge n+2. `mem_dq_oe` is low in every other cycle.
- R5: For a read sampled on edge n, the value on `mem_dq_in` in the cycle after edge n+2 is presented on `usr_rdata`, with `usr_rvalid` high for one cycle, after edge n+3. `usr_rvalid` is high only in such cycles.
- R6: Reads and writes can alternate in any order on every cycle without gaps. The controller's bus drive never overlaps the memory's read drive.
- R7: `mem_bw_n` is all zeros (every byte written) and `mem_adv_ld` is 0 (load a new address) at all times after reset.
- R8: Each read returns the word held at its address after all writes issued before it, including a write on the directly preceding cycle to the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the memory |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_wr | input | 1 | Write strobe, 1 = write this cycle |
| usr_rd | input | 1 | Read strobe, 1 = read this cycle |
| usr_addr | input | AW | Word address of the request |
| usr_wdata | input | DW | Write word, sampled with the write strobe |
| usr_rdata | output | DW | Returned read word |
| usr_rvalid | output | 1 | One-cycle flag marking `usr_rdata` valid |
| mem_addr | output | AW | Memory address pins |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_bw_n | output | DW/8 | Byte write enables, active low |
| mem_adv_ld | output | 1 | Burst advance / load select, 0 = load |
| mem_dq_out | output | DW | Word the controller drives onto the data bus |
| mem_dq_oe | output | 1 | Controller drive enable for the data bus |
| mem_dq_in | input | DW | Data bus as seen by the controller |

## Verification
Command pins are due one edge after the request. The write word and its drive enable are due three edges after the request. Read data with its valid flag is due four edges after the request. The bench shifts each request it issues into its own four-deep history, which advances on the rising edge. At each falling edge it compares the pins against the history entry whose age matches that latency. An expected read word is taken from a reference array at the moment the read is issued. The behavioural memory written in the bench applies the late-late timing on its own side, so both ends of the alignment are checked. Its drive enable is also compared against the controller's to catch bus contention.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  // Memory latency in edges between command registration and data transfer.
  localparam int MEM_LAT = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } zbt_op_e;

  // Write takes priority over read when both strobes are set.
  function automatic zbt_op_e decode_op(input logic wr, input logic rd);
    if (wr)      return OP_WRITE;
    else if (rd) return OP_READ;
    else         return OP_IDLE;
  endfunction
endpackage

// File: rtl/zbt_pipe.sv
module zbt_pipe #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= d;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= '0;
        else        stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/zbt_cmd_reg.sv
module zbt_cmd_reg
  import zbt_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_wr,
  input  logic          req_rd,
  input  logic [AW-1:0] req_addr,
  output logic [AW-1:0] cmd_addr,
  output logic          cmd_ce_n,
  output logic          cmd_we_n,
  output logic          take_wr,
  output logic          take_rd
);
  zbt_op_e op;

  assign op      = decode_op(req_wr, req_rd);
  assign take_wr = (op == OP_WRITE);
  assign take_rd = (op == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_addr <= '0;
      cmd_ce_n <= 1'b1;
      cmd_we_n <= 1'b1;
    end else begin
      cmd_ce_n <= (op == OP_IDLE);
      cmd_we_n <= (op != OP_WRITE);
      if (op != OP_IDLE) cmd_addr <= req_addr;
    end
  end
endmodule

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            usr_wr,
  input  logic            usr_rd,
  input  logic [AW-1:0]   usr_addr,
  input  logic [DW-1:0]   usr_wdata,
  output logic [DW-1:0]   usr_rdata,
  output logic            usr_rvalid,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_ce_n,
  output logic            mem_we_n,
  output logic [DW/8-1:0] mem_bw_n,
  output logic            mem_adv_ld,
  output logic [DW-1:0]   mem_dq_out,
  output logic            mem_dq_oe,
  input  logic [DW-1:0]   mem_dq_in
);
  localparam int NBYTE = DW / 8;
  // One command register stage plus the memory's own latency.
  localparam int DUE   = MEM_LAT + 1;

  logic          take_wr, take_rd;
  logic [DW:0]   wr_due;
  logic          rd_due;

  zbt_cmd_reg #(.AW(AW)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_wr   (usr_wr),
    .req_rd   (usr_rd),
    .req_addr (usr_addr),
    .cmd_addr (mem_addr),
    .cmd_ce_n (mem_ce_n),
    .cmd_we_n (mem_we_n),
    .take_wr  (take_wr),
    .take_rd  (take_rd)
  );

  // Write word and its pending flag travel together.
  zbt_pipe #(.W(DW + 1), .DEPTH(DUE)) u_wr_line (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({take_wr, take_wr ? usr_wdata : {DW{1'b0}}}),
    .q     (wr_due)
  );

  zbt_pipe #(.W(1), .DEPTH(DUE)) u_rd_line (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (take_rd),
    .q     (rd_due)
  );

  assign mem_dq_oe  = wr_due[DW];
  assign mem_dq_out = wr_due[DW-1:0];
  assign mem_bw_n   = {NBYTE{1'b0}};
  assign mem_adv_ld = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_rvalid <= 1'b0;
      usr_rdata  <= '0;
    end else begin
      usr_rvalid <= rd_due;
      if (rd_due) usr_rdata <= mem_dq_in;
    end
  end
endmodule

// File: rtl/zbt_ctrl_checker.sv
module zbt_ctrl_checker #(
  parameter int AW = 18,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            usr_wr,
  input logic            usr_rd,
  input logic [AW-1:0]   usr_addr,
  input logic [DW-1:0]   usr_wdata,
  input logic [DW-1:0]   usr_rdata,
  input logic            usr_rvalid,
  input logic [AW-1:0]   mem_addr,
  input logic            mem_ce_n,
  input logic            mem_we_n,
  input logic [DW/8-1:0] mem_bw_n,
  input logic            mem_adv_ld,
  input logic [DW-1:0]   mem_dq_out,
  input logic            mem_dq_oe,
  input logic [DW-1:0]   mem_dq_in
);
  assert_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_wr || usr_rd) |=> (!mem_ce_n && mem_addr == $past(usr_addr)));

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(usr_wr || usr_rd) |=> mem_ce_n);

  assert_wr_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
    usr_wr |=> !mem_we_n);

  assert_wr_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    usr_wr |=> ##2 (mem_dq_oe && mem_dq_out == $past(usr_wdata, 3)));

  assert_oe_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> $past(usr_wr, 3));

  assert_rvalid_due_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_rd && !usr_wr) |=> ##3 usr_rvalid);

  assert_rdata_R5: assert property (@(posedge clk) disable iff (!rst_n)
    usr_rvalid |-> usr_rdata == $past(mem_dq_in));

  assert_ties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_bw_n == '0) && !mem_adv_ld);
endmodule

bind zbt_ctrl zbt_ctrl_checker #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_zbt_ctrl.sv
module test_zbt_ctrl;
  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic          wr;
    logic          rd;
    logic [AW-1:0] a;
    logic [DW-1:0] wd;
    logic [DW-1:0] ex;
  } req_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            usr_wr = 1'b0, usr_rd = 1'b0;
  logic [AW-1:0]   usr_addr = '0;
  logic [DW-1:0]   usr_wdata = '0;
  logic [DW-1:0]   usr_rdata;
  logic            usr_rvalid;
  logic [AW-1:0]   mem_addr;
  logic            mem_ce_n, mem_we_n, mem_adv_ld, mem_dq_oe;
  logic [DW/8-1:0] mem_bw_n;
  logic [DW-1:0]   mem_dq_out, mem_dq_in;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  zbt_ctrl #(.AW(AW), .DW(DW)) i_zbt_ctrl (.*);

  // Behavioural late-late SRAM
  logic [DW-1:0] mdl_mem [DEPTH];
  logic          s1_v = 0, s1_w = 0, s2_v = 0, s2_w = 0;
  logic [AW-1:0] s1_a = '0, s2_a = '0;
  logic          mdl_oe = 0;
  logic [DW-1:0] mdl_dq = '0;

  always @(posedge clk) begin
    if (s2_v && s2_w && mem_dq_oe) mdl_mem[s2_a] = mem_dq_out;
    s2_v <= s1_v; s2_w <= s1_w; s2_a <= s1_a;
    s1_v <= !mem_ce_n; s1_w <= !mem_we_n; s1_a <= mem_addr;
    mdl_oe <= s1_v && !s1_w;
    mdl_dq <= (s1_v && !s1_w) ? mdl_mem[s1_a] : '0;
  end
  assign mem_dq_in = mdl_oe ? mdl_dq : '0;

  // Reference and request history
  logic [DW-1:0] ref_mem [DEPTH];
  req_t h1 = '0, h2 = '0, h3 = '0, h4 = '0;

  always @(posedge clk) begin
    req_t cur;
    cur    = '0;
    cur.wr = usr_wr;
    cur.rd = usr_rd && !usr_wr;
    cur.a  = usr_addr;
    cur.wd = usr_wdata;
    cur.ex = ref_mem[usr_addr];
    if (rst_n && usr_wr) ref_mem[usr_addr] = usr_wdata;
    if (!rst_n) cur = '0;
    h4 <= h3; h3 <= h2; h2 <= h1; h1 <= cur;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Port checks each falling edge
  always @(negedge clk) begin
    if (!rst_n || done) begin
    end else begin
      check(mem_ce_n == !(h1.wr || h1.rd), "R2 ce_n", 64'(mem_ce_n), 64'(!(h1.wr || h1.rd)));
      if (h1.wr || h1.rd) check(mem_addr == h1.a, "R2 addr", 64'(mem_addr), 64'(h1.a));
      check(mem_we_n == !h1.wr, "R3 we_n", 64'(mem_we_n), 64'(!h1.wr));
      check(mem_dq_oe == h3.wr, "R4 oe", 64'(mem_dq_oe), 64'(h3.wr));
      if (h3.wr) check(mem_dq_out == h3.wd, "R4 wdata", 64'(mem_dq_out), 64'(h3.wd));
      check(usr_rvalid == h4.rd, "R5 rvalid", 64'(usr_rvalid), 64'(h4.rd));
      if (h4.rd && usr_rvalid)
        check(usr_rdata == h4.ex, "R5/R8 rdata", 64'(usr_rdata), 64'(h4.ex));
      check(!(mdl_oe && mem_dq_oe), "R6 contention", 64'(mdl_oe), 64'(0));
      check(mem_bw_n == '0 && mem_adv_ld == 1'b0, "R7 ties", 64'({mem_bw_n, mem_adv_ld}), 64'(0));
    end
  end

  task automatic issue(input logic w, input logic r, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    #1;
    usr_wr = w; usr_rd = r; usr_addr = a; usr_wdata = d;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5a17);
    for (int i = 0; i < DEPTH; i++) begin
      mdl_mem[i] = DW'(i * 37 + 5);
      ref_mem[i] = DW'(i * 37 + 5);
    end
    // R1: reset state, during reset and just after release
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_we_n && !mem_dq_oe && !usr_rvalid, "R1 in reset",
          64'({mem_ce_n, mem_we_n, mem_dq_oe, usr_rvalid}), 64'(4'b1100));
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_ce_n && mem_we_n && !mem_dq_oe && !usr_rvalid, "R1 after reset",
          64'({mem_ce_n, mem_we_n, mem_dq_oe, usr_rvalid}), 64'(4'b1100));

    // R8: write then read the same address on the next cycle
    issue(1, 0, 6'd9, 16'hBEEF);
    issue(0, 1, 6'd9, 16'h0);
    // R3: both strobes -> write only, then read it back
    issue(1, 1, 6'd12, 16'h1234);
    issue(0, 1, 6'd12, 16'h0);
    // R6: strict alternation with no gap
    for (int i = 0; i < 8; i++) issue(i[0] ? 1'b0 : 1'b1, i[0], 6'(20 + i / 2), DW'(16'hA000 + i));
    // R6: read burst then write burst then read back
    for (int i = 0; i < 4; i++) issue(0, 1, 6'(i), '0);
    for (int i = 0; i < 4; i++) issue(1, 0, 6'(i), DW'(16'hC0 + i));
    for (int i = 0; i < 4; i++) issue(0, 1, 6'(i), '0);
    issue(0, 0, '0, '0);
    repeat (5) issue(0, 0, '0, '0);

    // Random mix on consecutive cycles, few addresses to force hazards
    for (int i = 0; i < 800; i++) begin
      int unsigned r;
      r = $urandom;
      issue(r[0], r[1], 6'(r[4:2]) + (r[5] ? 6'd32 : 6'd0), DW'(r >> 8));
    end
    repeat (6) issue(0, 0, '0, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule